// File: doc/BRIEF.md
# Five-Operation Integer ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for a datapath of configurable width, 32 bits by default. Two operands and a 3-bit operation code go in, and a result word comes out. The unit also reports three flags: a zero flag, a signed overflow flag and a carry-out flag. It performs bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than compare.

The unit is a ripple chain of identical bit slices. Each slice picks its output from four candidates with a 4-way select driven by the low two opcode bits. The candidates are the AND, the OR, the adder sum, and a "less" input that is live only in slice 0.

The high opcode bit does two jobs. It inverts B on its way into the adder, and it is the carry into bit 0. Subtraction therefore shares the adder with addition. The compare takes the sign of A minus B, corrects it for overflow, and routes it into bit 0.

The unit has no clock and no handshake. The outputs follow the inputs within one combinational delay, and the surrounding pipeline registers them.

Top module: `alu5_core`

## Requirements
- R1: Opcode 3'b000 gives result = A & B, bit by bit.
- R2: Opcode 3'b001 gives result = A | B, bit by bit.
- R3: Opcode 3'b010 gives result = (A + B) mod 2^W. The carry flag is bit W of the (W+1)-bit unsigned sum.
- R4: Opcode 3'b110 gives result = (A - B) mod 2^W, computed as A + ~B + 1. The carry flag is the carry out of that sum, so it is 1 exactly when A >= B as unsigned values.
- R5: Opcode 3'b111 sets result bit 0 to 1 when A < B as two's-complement values, and to 0 otherwise. All other result bits are 0. The compare is correct even when A - B overflows.
- R6: For opcodes 3'b010 and 3'b110, the overflow flag is 1 exactly when the two's-complement result of the add or subtract falls outside the signed W-bit range.
- R7: For every opcode, the zero flag is 1 exactly when all W result bits are 0.
- R8: Opcodes 3'b011, 3'b100 and 3'b101 are unused. For them the result is 0, overflow is 0, carry is 0 and zero is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W (32) | Operand A |
| b_i | input | W (32) | Operand B |
| op_i | input | 3 | Operation code |
| result_o | output | W (32) | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of the add/subtract path |
| carry_o | output | 1 | Carry out of the most significant slice |

## Verification
The bench builds the unit at its default width of 32. At that width the sign-boundary operands 0x7FFFFFFF and 0x80000000 sit exactly at the edges of the signed range. This makes overflow on both add and subtract reachable, and so is the compare case where the raw sign of A minus B is wrong and must be inverted. All ones and zero as operands drive the carry chain fully through all 32 slices and exercise the zero flag. Seeded random operands fill in the ordinary cases for all eight opcodes.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Index of each candidate in a slice's 4-way select
  localparam logic [1:0] SEL_AND  = 2'd0;
  localparam logic [1:0] SEL_OR   = 2'd1;
  localparam logic [1:0] SEL_SUM  = 2'd2;
  localparam logic [1:0] SEL_LESS = 2'd3;

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
           (op == OP_SUB) || (op == OP_SLT);
  endfunction
endpackage

// File: rtl/alu5_slice.sv
module alu5_slice
  import alu5_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       r_o,
  output logic       cout_o
);
  logic b_eff;
  logic sum;

  assign b_eff  = b_i ^ binv_i;
  assign sum    = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (cin_i & (a_i ^ b_eff));

  always_comb begin
    unique case (sel_i)
      SEL_AND:  r_o = a_i & b_eff;
      SEL_OR:   r_o = a_i | b_eff;
      SEL_SUM:  r_o = sum;
      SEL_LESS: r_o = less_i;
      default:  r_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu5_msb_flags.sv
module alu5_msb_flags (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic binv_i,
  input  logic c_into_msb_i,
  input  logic c_out_msb_i,
  output logic ovf_o,
  output logic set_o
);
  logic msb_sum;

  assign ovf_o   = c_into_msb_i ^ c_out_msb_i;
  assign msb_sum = a_msb_i ^ (b_msb_i ^ binv_i) ^ c_into_msb_i;
  // When the difference overflows, its sign bit is the wrong way round
  assign set_o   = msb_sum ^ ovf_o;
endmodule

// File: rtl/alu5_zero_detect.sv
module alu5_zero_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] r_i,
  output logic         zero_o
);
  assign zero_o = ~(|r_i);
endmodule

// File: rtl/alu5_core.sv
module alu5_core
  import alu5_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o,
  output logic            ovf_o,
  output logic            carry_o
);
  localparam int unsigned MSB = W - 1;

  logic [W:0]   carry;
  logic [W-1:0] raw;
  logic         binv;
  logic         set_bit;
  logic         ovf_raw;
  logic         op_ok;

  assign binv     = op_i[2];
  assign carry[0] = op_i[2];
  assign op_ok    = op_defined(op_i);

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = set_bit;
    end else begin : g_rest
      assign less_in = 1'b0;
    end
    alu5_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .binv_i (binv),
      .cin_i  (carry[i]),
      .less_i (less_in),
      .sel_i  (op_i[1:0]),
      .r_o    (raw[i]),
      .cout_o (carry[i+1])
    );
  end

  alu5_msb_flags u_msb (
    .a_msb_i      (a_i[MSB]),
    .b_msb_i      (b_i[MSB]),
    .binv_i       (binv),
    .c_into_msb_i (carry[MSB]),
    .c_out_msb_i  (carry[W]),
    .ovf_o        (ovf_raw),
    .set_o        (set_bit)
  );

  assign result_o = op_ok ? raw : '0;
  assign ovf_o    = op_ok & ovf_raw;
  assign carry_o  = op_ok & carry[W];

  alu5_zero_detect #(.W(W)) u_zero (
    .r_i    (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/alu5_checker.sv
module alu5_checker
  import alu5_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    result_o,
  input logic            zero_o,
  input logic            ovf_o,
  input logic            carry_o
);
  logic [W-1:0] diff;
  assign diff = a_i - b_i;

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      p_and_r1: assert (op_i != OP_AND || result_o == (a_i & b_i));
      p_add_r3: assert (op_i != OP_ADD || result_o == a_i + b_i);
      p_sub_r4: assert (op_i != OP_SUB || result_o == diff);
      p_slt_high_zero_r5: assert (op_i != OP_SLT || result_o[W-1:1] == '0);
      p_ovf_sub_r6: assert (op_i != OP_SUB ||
        ovf_o == ((a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1])));
      p_zero_r7: assert (zero_o == (result_o == '0));
      p_unused_r8: assert (op_defined(op_i) ||
        (result_o == '0 && !ovf_o && !carry_o));
    end
  end
endmodule

bind alu5_core alu5_checker #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .result_o(result_o),
  .zero_o(zero_o), .ovf_o(ovf_o), .carry_o(carry_o)
);

// File: tb/sim_alu5_core.sv
module sim_alu5_core;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned N_RAND = 400;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } vec_t;

  localparam int unsigned N_VEC = 12;
  localparam vec_t VECS [0:N_VEC-1] = '{
    '{3'b000, 32'hF0F0_1234, 32'hFF00_00FF},
    '{3'b001, 32'h0F0F_0000, 32'h00F0_1001},
    '{3'b010, 32'h0000_0003, 32'h0000_0002},
    '{3'b010, 32'hFFFF_FFFF, 32'h0000_0001},
    '{3'b010, 32'h7FFF_FFFF, 32'h0000_0001},
    '{3'b110, 32'h0000_0003, 32'h0000_0002},
    '{3'b110, 32'h8000_0000, 32'h0000_0001},
    '{3'b110, 32'h0000_0005, 32'h0000_0005},
    '{3'b111, 32'hFFFF_FFFA, 32'hFFFF_FFFB},
    '{3'b111, 32'h8000_0000, 32'h7FFF_FFFF},
    '{3'b111, 32'h7FFF_FFFF, 32'h8000_0000},
    '{3'b011, 32'h1234_5678, 32'h9ABC_DEF0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] result;
  logic zero, ovf, carry;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu5_core #(.W(W)) u0 (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(result), .zero_o(zero), .ovf_o(ovf), .carry_o(carry)
  );

  task automatic check1(input string tag, input logic [W:0] got,
                        input logic [W:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
               tag, op, a, b, got, exp);
    end
  endtask

  // Reference model written straight from the requirements
  task automatic apply_and_check(input logic [2:0] o, input logic [W-1:0] x,
                                 input logic [W-1:0] y);
    logic [W-1:0] er;
    logic ev, ec, arith;
    logic [W:0] wide;
    @(negedge clk);
    op = o; a = x; b = y;
    #(CLK_PERIOD/4);
    er = '0; ev = 1'b0; ec = 1'b0; arith = 1'b0;
    case (o)
      3'b000: er = x & y;                                   // R1
      3'b001: er = x | y;                                   // R2
      3'b010: begin                                         // R3
        wide = {1'b0, x} + {1'b0, y};
        er = wide[W-1:0]; ec = wide[W]; arith = 1'b1;
        ev = ($signed(x) + $signed(y) > 64'sd0) != 1'b0 &&
             (x[W-1] == y[W-1]) && (er[W-1] != x[W-1]);
      end
      3'b110: begin                                         // R4
        er = x - y; ec = (x >= y); arith = 1'b1;
        ev = (x[W-1] != y[W-1]) && (er[W-1] != x[W-1]);
      end
      3'b111: er = {{(W-1){1'b0}}, ($signed(x) < $signed(y))}; // R5
      default: begin er = '0; ev = 1'b0; ec = 1'b0; arith = 1'b1; end // R8
    endcase
    if (o == 3'b010) ev = (x[W-1] == y[W-1]) && (er[W-1] != x[W-1]);
    case (o)
      3'b000: check1("R1 result", {1'b0, result}, {1'b0, er});
      3'b001: check1("R2 result", {1'b0, result}, {1'b0, er});
      3'b010: check1("R3 result", {1'b0, result}, {1'b0, er});
      3'b110: check1("R4 result", {1'b0, result}, {1'b0, er});
      3'b111: check1("R5 result", {1'b0, result}, {1'b0, er});
      default: check1("R8 result", {1'b0, result}, {1'b0, er});
    endcase
    if (arith) begin
      check1((o == 3'b010 || o == 3'b110) ? "R6 overflow" : "R8 overflow",
             {{W{1'b0}}, ovf}, {{W{1'b0}}, ev});
      check1((o == 3'b010) ? "R3 carry" : (o == 3'b110) ? "R4 carry" : "R8 carry",
             {{W{1'b0}}, carry}, {{W{1'b0}}, ec});
    end
    check1("R7 zero", {{W{1'b0}}, zero}, {{W{1'b0}}, (er == '0)});
  endtask

  initial begin
    logic [W-1:0] corners [0:3];
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = {1'b0, {(W-1){1'b1}}};
    corners[3] = {1'b1, {(W-1){1'b0}}};
    a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: zero operands under AND give zero result and zero flag (R1, R7)
    @(negedge clk);
    check1("R1 reset result", {1'b0, result}, '0);
    check1("R7 reset zero", {{W{1'b0}}, zero}, {{W{1'b0}}, 1'b1});
    for (int i = 0; i < N_VEC; i++)
      apply_and_check(VECS[i].op, VECS[i].a, VECS[i].b);
    // Directed corners: every opcode against every corner pair
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply_and_check(3'(o), corners[i], corners[j]);
    // Seeded random operands over all opcodes
    void'($urandom(32'h5EED));
    for (int k = 0; k < N_RAND; k++)
      apply_and_check(3'(k % 8), W'($urandom), W'($urandom));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule